// File: doc/BRIEF.md
# Configurable Timer/Counter with Prescaler

This peripheral counts either pulses of an internal tick enable or edges on an external clock pin. The counter can wrap at 8 or 16 bits, and counts can pass through a power-of-two prescaler or bypass it. One packed control byte sets all of this. Software reads and preloads the count over a small byte-wide register bus. When the count wraps to zero, a sticky overflow flag is set and driven out as an interrupt request. Software clears the flag.

The external pin is asynchronous to the block clock. It passes through a two-stage synchronizer and then an edge detector before it can advance the prescaler or the counter. In 16-bit mode the upper byte goes through a buffer, so that software can read and write the full 16-bit count as one indivisible value using two byte accesses.

Register map (byte addresses): 0 is the count low byte, 1 is the high-byte buffer, 2 is the control byte, and 3 is the flag (bit 0).

Top module: `tmr_unit`

## Requirements
- R1: After reset the control byte, the count and the flag are all zero, and irq_o is low.
- R2: Control bit 7 is the run enable. While it is 0 the count holds its value, whatever tick_i and ext_clk_i do.
- R3: Control bit 6 selects the width. When it is 1, only the low byte counts and it wraps from FFh to 00h while the high byte holds. When it is 0, the full count wraps from FFFFh to 0000h.
- R4: Control bit 5 selects the count source. When it is 1, the source is edges on ext_clk_i after a two-flop synchronizer, and tick_i is ignored. When it is 0, the source is each cycle with tick_i high.
- R5: Control bit 4 selects the external edge. When it is 1, falling edges count; when it is 0, rising edges count. Each qualifying edge produces exactly one source pulse.
- R6: Control bit 3 set to 1 bypasses the prescaler, so every source pulse advances the count. Control bit 3 set to 0 sends source pulses through the prescaler. Control bits 2:0, with value s, then give one count per 2^(s+1) source pulses (000 gives 1:2, 111 gives 1:256).
- R7: A wrap of the count sets the flag, which drives irq_o. A write of 0 to bit 0 of address 3 clears the flag. A write of 1 leaves it unchanged.
- R8: If a wrap and a clearing write to the flag occur in the same cycle, the flag ends up set.
- R9: A write to address 0 preloads the count, clears the prescaler, and takes priority over a count pulse in the same cycle.
- R10: In 16-bit mode, a read of address 0 copies the current high byte into the buffer, and address 1 reads and writes that buffer. A write to address 0 loads the buffer and the written byte together into the count. In 8-bit mode, a write to address 0 changes only the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Internal count source, one pulse per cycle high |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| bus_addr_i | input | 2 | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe (latches the high byte on a low-byte read) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Overflow flag, interrupt request |

## Verification
The assertions check a set of invariants on every cycle. A stopped counter holds its value, and the high byte does not move in 8-bit mode. A full-width wrap lands on zero with the flag set. The flag stays set until a clearing write arrives, and a wrap in the same cycle as that write leaves it set. A preload wins over a count, the prescaler only fires on a source pulse, and the edge detector never pulses two cycles in a row. Other behaviours depend on history that a single-cycle property cannot express, so only the bench scenarios show them. These are the exact divide count for each of the eight prescale settings, the number of counts from a train of external edges of each polarity, the high-byte buffer that holds its snapshot while the count moves on, and the prescaler reset by a preload.

// File: rtl/tmr_unit_pkg.sv
package tmr_unit_pkg;
  localparam int PS_SEL_W = 3;
  localparam int PSC_W    = 2 ** PS_SEL_W;

  typedef struct packed {
    logic                en;
    logic                narrow;
    logic                ext_src;
    logic                fall_edge;
    logic                psc_bypass;
    logic [PS_SEL_W-1:0] ps_sel;
  } ctrl_t;

  typedef enum logic [1:0] {
    A_CNT_LO = 2'd0,
    A_CNT_HI = 2'd1,
    A_CTRL   = 2'd2,
    A_FLAG   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_unit_sync.sv
module tmr_unit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= pin_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  logic rise, fall;
  assign rise   = sync_q[STAGES-1] & ~prev_q;
  assign fall   = ~sync_q[STAGES-1] & prev_q;
  assign edge_o = fall_sel_i ? fall : rise;

  // R5
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o);
endmodule

// File: rtl/tmr_unit_psc.sv
module tmr_unit_psc
  import tmr_unit_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                src_i,
  input  logic                bypass_i,
  input  logic [PS_SEL_W-1:0] sel_i,
  input  logic                clr_i,
  output logic                pulse_o
);
  logic [PSC_W-1:0] pre_q;
  logic [PSC_W-1:0] mask;
  logic             full;

  // ratio 2^(sel+1): terminal value is the low sel+1 bits all set
  assign mask = ~({PSC_W{1'b1}} << (int'(sel_i) + 1));
  assign full = (pre_q & mask) == mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (clr_i)               pre_q <= '0;
    else if (src_i && !bypass_i) begin
      if (full) pre_q <= '0;
      else      pre_q <= pre_q + 1'b1;
    end
  end

  assign pulse_o = bypass_i ? src_i : (src_i & full);

  // R6
  psc_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> src_i);
  // R9
  psc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);
endmodule

// File: rtl/tmr_unit_core.sv
module tmr_unit_core #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             narrow_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_flag_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             lo_top, wrap;

  assign lo_top = &cnt_q[BYTE_W-1:0];
  assign wrap   = inc_i & ~load_i & (narrow_i ? lo_top : &cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= load_val_i;
    else if (inc_i) begin
      if (narrow_i) cnt_q[BYTE_W-1:0] <= cnt_q[BYTE_W-1:0] + 1'b1;
      else          cnt_q <= cnt_q + 1'b1;
    end
  end

  // overflow beats the clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (clr_flag_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R3
  narrow_hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_i && !load_i) |=> cnt_q[CNT_W-1:BYTE_W] == $past(cnt_q[CNT_W-1:BYTE_W]));
  // R3
  wide_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && !narrow_i && cnt_q == '1) |=> (cnt_q == '0 && flag_q));
  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_flag_i) |=> flag_q);
  // R8
  ovf_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && narrow_i && lo_top && clr_flag_i) |=> flag_q);
  // R9
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_unit_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ext_clk_i,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * BYTE_W;

  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] hi_buf_q;
  logic [CNT_W-1:0]  cnt;
  logic              flag;
  logic              ext_edge, src, cnt_pulse;
  logic              wr_lo, wr_hi, wr_ctrl, wr_flag, rd_lo;
  logic [CNT_W-1:0]  load_val;

  assign wr_lo   = bus_we_i && bus_addr_i == A_CNT_LO;
  assign wr_hi   = bus_we_i && bus_addr_i == A_CNT_HI;
  assign wr_ctrl = bus_we_i && bus_addr_i == A_CTRL;
  assign wr_flag = bus_we_i && bus_addr_i == A_FLAG;
  assign rd_lo   = bus_re_i && bus_addr_i == A_CNT_LO;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[7:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_buf_q <= '0;
    else if (wr_hi)                  hi_buf_q <= bus_wdata_i;
    else if (rd_lo && !ctrl_q.narrow) hi_buf_q <= cnt[CNT_W-1:BYTE_W];
  end

  assign load_val = ctrl_q.narrow ? {cnt[CNT_W-1:BYTE_W], bus_wdata_i}
                                  : {hi_buf_q, bus_wdata_i};

  tmr_unit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_clk_i),
    .fall_sel_i (ctrl_q.fall_edge),
    .edge_o     (ext_edge)
  );

  assign src = ctrl_q.en & (ctrl_q.ext_src ? ext_edge : tick_i);

  tmr_unit_psc u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src),
    .bypass_i (ctrl_q.psc_bypass),
    .sel_i    (ctrl_q.ps_sel),
    .clr_i    (wr_lo),
    .pulse_o  (cnt_pulse)
  );

  tmr_unit_core #(.BYTE_W(BYTE_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (cnt_pulse),
    .narrow_i   (ctrl_q.narrow),
    .load_i     (wr_lo),
    .load_val_i (load_val),
    .clr_flag_i (wr_flag & ~bus_wdata_i[0]),
    .cnt_o      (cnt),
    .flag_o     (flag)
  );

  always_comb begin
    unique case (bus_addr_i)
      A_CNT_LO: bus_rdata_o = cnt[BYTE_W-1:0];
      A_CNT_HI: bus_rdata_o = hi_buf_q;
      A_CTRL:   bus_rdata_o = BYTE_W'(ctrl_q);
      default:  bus_rdata_o = BYTE_W'(flag);
    endcase
  end

  assign irq_o = flag;

  // R2
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.en && !wr_lo) |=> $stable(cnt));
  // R4
  ext_ignores_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.ext_src && !ext_edge) |-> !src);
endmodule

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ext = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_clk_i(ext),
    .bus_addr_i(addr), .bus_we_i(we), .bus_re_i(re),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext = 1'b1; repeat (4) @(negedge clk);
      ext = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic preload(input logic [7:0] hi, input logic [7:0] lo);
    wr(2'd1, hi); wr(2'd0, lo);
  endtask

  initial begin
    logic [7:0] b;
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd2, b); check("R1 ctrl", b, 8'h00);
    rd16(v);     check("R1 count", v, 0);
    rd(2'd3, b); check("R1 flag", b, 0);
    check("R1 irq", irq, 0);

    // R2 disabled: ticks ignored
    wr(2'd2, 8'h08); ticks(10);
    rd16(v); check("R2 stopped count", v, 0);

    // R6 bypass: one count per tick
    wr(2'd2, 8'h88); ticks(10);
    rd16(v); check("R6 bypass count", v, 10);

    // R6 prescale sweep: 4*ratio-1 ticks give 3 counts
    for (int s = 0; s < 8; s++) begin
      wr(2'd2, 8'h80 | 8'(s)); preload(8'h00, 8'h00);
      ticks(4 * (2 << s) - 1);
      rd16(v); check($sformatf("R6 ratio sel %0d", s), v, 3);
    end

    // R3/R7/R10 narrow wrap keeps high byte
    wr(2'd2, 8'h88); preload(8'h12, 8'hFD);
    wr(2'd2, 8'hC8); ticks(2);
    rd(2'd0, b); check("R3 narrow pre-wrap", b, 8'hFF);
    check("R7 no flag before wrap", irq, 0);
    ticks(1);
    rd(2'd0, b); check("R3 narrow wrap low", b, 8'h00);
    check("R7 flag on narrow wrap", irq, 1);
    wr(2'd2, 8'h08); rd16(v); check("R3 narrow high held", v, 16'h1200);

    // R7 clear by 0, write of 1 ignored
    wr(2'd3, 8'h00); check("R7 flag cleared", irq, 0);
    wr(2'd3, 8'h01); rd(2'd3, b); check("R7 write 1 ignored", b, 0);

    // R10 narrow write touches low byte only
    wr(2'd2, 8'hC8); wr(2'd1, 8'h55); wr(2'd0, 8'h33);
    wr(2'd2, 8'h08); rd16(v); check("R10 narrow load low only", v, 16'h1233);

    // R3 wide wrap
    wr(2'd2, 8'h88); preload(8'hFF, 8'hFE); ticks(1);
    rd16(v); check("R3 wide pre-wrap", v, 16'hFFFF);
    check("R7 no flag at FFFF", irq, 0);
    ticks(1);
    rd16(v); check("R3 wide wrap", v, 0);
    check("R7 flag on wide wrap", irq, 1);

    // R8 wrap in same cycle as clear
    wr(2'd3, 8'h00); preload(8'hFF, 8'hFF);
    @(negedge clk); addr = 2'd3; wdata = 8'h00; we = 1'b1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    check("R8 overflow beats clear", irq, 1);
    wr(2'd3, 8'h00);

    // R9 preload beats a count pulse
    wr(2'd1, 8'h00);
    @(negedge clk); addr = 2'd0; wdata = 8'h05; we = 1'b1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    rd16(v); check("R9 load over increment", v, 5);

    // R9 preload clears prescaler (ratio 1:4)
    wr(2'd2, 8'h81); preload(8'h00, 8'h00); ticks(3);
    wr(2'd0, 8'h00); ticks(3);
    rd16(v); check("R9 prescaler cleared", v, 0);
    ticks(1); rd16(v); check("R9 count after clear", v, 1);

    // R10 high-byte snapshot on low read
    wr(2'd2, 8'h88); preload(8'h12, 8'hFF); wr(2'd1, 8'h77);
    rd(2'd0, b); check("R10 low read", b, 8'hFF);
    ticks(1);
    rd(2'd1, b); check("R10 buffered high held", b, 8'h12);
    rd16(v); check("R10 new count", v, 16'h1300);

    // R4/R5 external rising edges, tick ignored
    wr(2'd2, 8'hA8); preload(8'h00, 8'h00);
    tick = 1'b1; ext_pulses(5); tick = 1'b0;
    repeat (4) @(negedge clk);
    rd16(v); check("R4 R5 rising ext count", v, 5);

    // R5 falling edges; final rise not counted
    wr(2'd2, 8'hB8); preload(8'h00, 8'h00);
    ext_pulses(3); ext = 1'b1; repeat (6) @(negedge clk);
    rd16(v); check("R5 falling ext count", v, 3);
    ext = 1'b0; repeat (6) @(negedge clk);
    rd16(v); check("R5 last falling edge", v, 4);

    // R6 external through prescaler 1:2
    wr(2'd2, 8'hA0); preload(8'h00, 8'h00);
    ext_pulses(6); repeat (4) @(negedge clk);
    rd16(v); check("R6 ext prescaled", v, 3);

    // R2 ext edges ignored while disabled
    wr(2'd2, 8'h28); preload(8'h00, 8'h00);
    ext_pulses(3); repeat (4) @(negedge clk);
    rd16(v); check("R2 ext stopped", v, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule